// File: doc/BRIEF.md
# Speculative Return Address Stack

This block predicts return addresses for a wide fetch front end that runs well ahead of commit. Fetch logic issues one request per clock, a push carrying the address that follows a call or a pop for a return. Each request is tagged with the identifier of the instruction bundle that produced it. The block answers with the predicted return address at the current speculative top of stack.

Speculative actions do not touch the committed stack directly. Each one becomes an entry in a small in-order queue, which records the operation, the stack position it leaves behind, the pushed address and the bundle tag. A prediction looks for the newest queued push whose recorded position matches the speculative top. If there is none, the prediction comes from the committed backing stack at that position. A push that later turns out to be wrong therefore cannot destroy an address that an older pop had consumed. After a misprediction the discarded entries leave the queue, and the surviving entries still describe the correct slot contents.

Bundle tags are allocated in ascending order and wrap around. Fewer than 2^TAG_W bundles may be in flight at once. When a bundle retires, its entries are marked committed and then drained one per clock into the backing stack. A wrong prediction costs only performance, because the branch unit repairs it through the ordinary misprediction path.

Top module: `spec_ras`

## Requirements
- R1: After reset, `pred_addr` is 0 and `top_index` is 0.
- R2: A push that is accepted while the queue is not full moves `top_index` up by one, with wrap. On the next clock `pred_addr` equals the pushed address.
- R3: A pop moves `top_index` down by one, with wrap. `pred_addr` then shows the newest queued push recorded at the new position, or the committed stack contents at that position if no such push is queued.
- R4: Once a push has been committed and drained, its address is served from the backing stack at its position.
- R5: A flush removes every uncommitted entry whose tag is younger than `flush_tag`. Age is measured as the tag distance from the last committed tag. `top_index` then returns to the position recorded by the youngest surviving entry. A slot that was popped and then overwritten by a discarded push predicts its original address again.
- R6: If no entry survives a flush, `top_index` returns to the committed top of stack.
- R7: Committed entries drain strictly in order, at most one per clock. A drained push writes the backing stack and sets the committed top. A drained pop only sets the committed top.
- R8: When the queue already holds QUEUE_DEPTH entries, a new request is not recorded, but `top_index` still moves.
- R9: The backing stack holds STACK_DEPTH (32) positions and wraps circularly. Pushing past the last position overwrites the oldest position.
- R10: A request that arrives in the same clock as a flush is ignored. `top_index` takes only the restored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Speculative stack request this clock |
| req_push | input | 1 | 1 = push (call), 0 = pop (return) |
| req_addr | input | ADDR_W | Return address to push |
| req_tag | input | TAG_W | Bundle tag of the request |
| commit_valid | input | 1 | A bundle has fully committed |
| commit_tag | input | TAG_W | Tag of the committed bundle |
| flush_valid | input | 1 | Misprediction recovery this clock |
| flush_tag | input | TAG_W | Tag of the bundle holding the mispredicted branch |
| pred_addr | output | ADDR_W | Predicted return address at the speculative top |
| top_index | output | log2(STACK_DEPTH) | Speculative top-of-stack position |

## Verification
A corrupt queue entry or a mis-ordered drain does not show up at once. It appears as a wrong `pred_addr` only when a later pop or flush brings the damaged position back to the top. The tests therefore always move the top back onto earlier positions and compare the address shown there. A wrong restore position after a flush shows up on `top_index` in the very next clock. A drain that skips or reorders an entry shows up as a wrong committed top after the following empty-queue flush.

// File: rtl/spec_ras_pkg.sv
// Shared definitions for the speculative return address stack.
// Assumes nothing beyond the parameter rules stated in each module.
package spec_ras_pkg;
    // Kind of action recorded in the speculative queue
    typedef enum logic {
        RAS_POP  = 1'b0,
        RAS_PUSH = 1'b1
    } ras_op_e;
endpackage

// File: rtl/ras_backing_stack.sv
// Committed circular return stack. It holds DEPTH addresses and the
// committed top position, and takes at most one drained action per clock.
// Assumes DEPTH is a power of two, so that positions wrap naturally.
module ras_backing_stack #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_push,
    input  logic [IDX_W-1:0]  wr_pos,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [IDX_W-1:0]  rd_pos,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [IDX_W-1:0]  cmt_tos
);
    logic [ADDR_W-1:0] mem [DEPTH];

    // Clear the stack on reset; apply one drained action per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            cmt_tos <= '0;
        end else if (wr_en) begin
            cmt_tos <= wr_pos;
            if (wr_push) mem[wr_pos] <= wr_addr;
        end
    end

    // Read port used when no queued push covers the current top
    always_comb rd_addr = mem[rd_pos];
endmodule

// File: rtl/ras_spec_queue.sv
// In-order queue of speculative push/pop actions. It marks entries committed
// by bundle tag, drains the oldest committed entry, truncates on a flush and
// reports the top position to restore. It also presents its entries in age
// order for the lookup.
// Assumes that QDEPTH is a power of two, that tags rise along the queue and
// that fewer than 2**TAG_W bundles are in flight.
module ras_spec_queue
    import spec_ras_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5,
    parameter int TAG_W  = 4,
    parameter int QDEPTH = 8,
    parameter int QP_W   = $clog2(QDEPTH),
    parameter int CNT_W  = $clog2(QDEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enq_valid,
    input  ras_op_e                       enq_op,
    input  logic [IDX_W-1:0]              enq_pos,
    input  logic [ADDR_W-1:0]             enq_addr,
    input  logic [TAG_W-1:0]              enq_tag,
    input  logic                          commit_valid,
    input  logic [TAG_W-1:0]              commit_tag,
    input  logic                          flush_valid,
    input  logic [TAG_W-1:0]              flush_tag,
    input  logic [IDX_W-1:0]              fallback_tos,
    output logic                          drain_valid,
    output ras_op_e                       drain_op,
    output logic [IDX_W-1:0]              drain_pos,
    output logic [ADDR_W-1:0]             drain_addr,
    output logic [IDX_W-1:0]              restore_tos,
    output logic [CNT_W-1:0]              q_count,
    output logic [QDEPTH-1:0]             ord_valid,
    output logic [QDEPTH-1:0]             ord_push,
    output logic [QDEPTH-1:0][IDX_W-1:0]  ord_pos,
    output logic [QDEPTH-1:0][ADDR_W-1:0] ord_addr
);
    ras_op_e           e_op   [QDEPTH];
    logic [IDX_W-1:0]  e_pos  [QDEPTH];
    logic [ADDR_W-1:0] e_addr [QDEPTH];
    logic [TAG_W-1:0]  e_tag  [QDEPTH];
    logic [QDEPTH-1:0] e_cmt;

    logic [QP_W-1:0]   head;
    logic [CNT_W-1:0]  count;
    logic [TAG_W-1:0]  last_cmt_tag;
    logic [QP_W-1:0]   tail;
    logic              enq_ok;
    logic [QDEPTH-1:0] keep;
    logic [CNT_W-1:0]  kept_cnt;
    logic [TAG_W-1:0]  flush_age;

    assign q_count = count;
    assign tail    = head + count[QP_W-1:0];
    assign enq_ok  = enq_valid && !flush_valid && (count < CNT_W'(QDEPTH));

    // Present the entries oldest first, for the lookup and for the flush scan
    always_comb begin
        for (int i = 0; i < QDEPTH; i++) begin
            ord_valid[i] = CNT_W'(i) < count;
            ord_push[i]  = e_op[head + QP_W'(i)] == RAS_PUSH;
            ord_pos[i]   = e_pos[head + QP_W'(i)];
            ord_addr[i]  = e_addr[head + QP_W'(i)];
        end
    end

    // Decide which entries survive a flush, and the top position to restore
    always_comb begin
        logic [TAG_W-1:0] slot_tag;
        logic [TAG_W-1:0] slot_age;
        logic             slot_cmt;
        flush_age   = flush_tag - last_cmt_tag;
        kept_cnt    = '0;
        restore_tos = fallback_tos;
        for (int i = 0; i < QDEPTH; i++) begin
            slot_tag = e_tag[head + QP_W'(i)];
            slot_age = slot_tag - last_cmt_tag;
            slot_cmt = e_cmt[head + QP_W'(i)] ||
                       (commit_valid && slot_tag == commit_tag);
            keep[i]  = ord_valid[i] && (slot_cmt || slot_age <= flush_age);
            kept_cnt = kept_cnt + CNT_W'(keep[i]);
            if (keep[i]) restore_tos = ord_pos[i];
        end
    end

    // The oldest entry leaves the queue once it has been committed
    always_comb begin
        drain_valid = (count != '0) && e_cmt[head];
        drain_op    = e_op[head];
        drain_pos   = e_pos[head];
        drain_addr  = e_addr[head];
    end

    // Pointer, occupancy, commit marking and commit-tag reference
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head         <= '0;
            count        <= '0;
            e_cmt        <= '0;
            last_cmt_tag <= '1;
        end else begin
            if (drain_valid) head <= head + 1'b1;
            if (flush_valid)
                count <= kept_cnt - CNT_W'(drain_valid);
            else
                count <= count - CNT_W'(drain_valid) + CNT_W'(enq_ok);
            if (commit_valid) begin
                last_cmt_tag <= commit_tag;
                for (int s = 0; s < QDEPTH; s++)
                    if (e_tag[s] == commit_tag) e_cmt[s] <= 1'b1;
            end
            if (enq_ok) e_cmt[tail] <= 1'b0;
        end
    end

    // Entry payload is written on enqueue only and needs no reset
    always_ff @(posedge clk) begin
        if (enq_ok) begin
            e_op[tail]   <= enq_op;
            e_pos[tail]  <= enq_pos;
            e_addr[tail] <= enq_addr;
            e_tag[tail]  <= enq_tag;
        end
    end
endmodule

// File: rtl/ras_lookup.sv
// Finds the newest queued push whose recorded position equals the speculative
// top. If there is none, it returns the backing stack word. Purely
// combinational; the entries arrive oldest first.
module ras_lookup #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5,
    parameter int QDEPTH = 8
) (
    input  logic [QDEPTH-1:0]             ord_valid,
    input  logic [QDEPTH-1:0]             ord_push,
    input  logic [QDEPTH-1:0][IDX_W-1:0]  ord_pos,
    input  logic [QDEPTH-1:0][ADDR_W-1:0] ord_addr,
    input  logic [IDX_W-1:0]              tos,
    input  logic [ADDR_W-1:0]             backing_addr,
    output logic [ADDR_W-1:0]             pred_addr
);
    // Scan oldest to newest so that the newest matching push wins
    always_comb begin
        pred_addr = backing_addr;
        for (int i = 0; i < QDEPTH; i++)
            if (ord_valid[i] && ord_push[i] && ord_pos[i] == tos)
                pred_addr = ord_addr[i];
    end
endmodule

// File: rtl/spec_ras.sv
// Speculative return address stack top level. It keeps the speculative top
// pointer, turns requests into queue entries, restores the pointer on a flush
// and connects the drain to the committed stack.
// Assumes at most one request per clock, tags allocated in ascending order,
// and STACK_DEPTH and QUEUE_DEPTH both powers of two.
module spec_ras
    import spec_ras_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int STACK_DEPTH = 32,
    parameter int QUEUE_DEPTH = 8,
    parameter int TAG_W       = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    input  logic                             req_push,
    input  logic [ADDR_W-1:0]                req_addr,
    input  logic [TAG_W-1:0]                 req_tag,
    input  logic                             commit_valid,
    input  logic [TAG_W-1:0]                 commit_tag,
    input  logic                             flush_valid,
    input  logic [TAG_W-1:0]                 flush_tag,
    output logic [ADDR_W-1:0]                pred_addr,
    output logic [$clog2(STACK_DEPTH)-1:0]   top_index
);
    localparam int IDX_W = $clog2(STACK_DEPTH);
    localparam int QP_W  = $clog2(QUEUE_DEPTH);
    localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);

    logic [IDX_W-1:0]                   spec_tos;
    logic [IDX_W-1:0]                   next_pos;
    ras_op_e                            req_op;
    logic                               drain_valid;
    ras_op_e                            drain_op;
    logic [IDX_W-1:0]                   drain_pos;
    logic [ADDR_W-1:0]                  drain_addr;
    logic [IDX_W-1:0]                   restore_tos;
    logic [IDX_W-1:0]                   cmt_tos;
    logic [CNT_W-1:0]                   q_count;
    logic [ADDR_W-1:0]                  backing_addr;
    logic [QUEUE_DEPTH-1:0]             ord_valid;
    logic [QUEUE_DEPTH-1:0]             ord_push;
    logic [QUEUE_DEPTH-1:0][IDX_W-1:0]  ord_pos;
    logic [QUEUE_DEPTH-1:0][ADDR_W-1:0] ord_addr;

    assign req_op    = req_push ? RAS_PUSH : RAS_POP;
    assign next_pos  = req_push ? spec_tos + 1'b1 : spec_tos - 1'b1;
    assign top_index = spec_tos;

    // Speculative top: restored on a flush, otherwise stepped by each request
    always_ff @(posedge clk) begin
        if (!rst_n)           spec_tos <= '0;
        else if (flush_valid) spec_tos <= restore_tos;
        else if (req_valid)   spec_tos <= next_pos;
    end

    ras_spec_queue #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .QDEPTH (QUEUE_DEPTH),
        .QP_W   (QP_W),
        .CNT_W  (CNT_W)
    ) u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .enq_valid    (req_valid),
        .enq_op       (req_op),
        .enq_pos      (next_pos),
        .enq_addr     (req_addr),
        .enq_tag      (req_tag),
        .commit_valid (commit_valid),
        .commit_tag   (commit_tag),
        .flush_valid  (flush_valid),
        .flush_tag    (flush_tag),
        .fallback_tos (cmt_tos),
        .drain_valid  (drain_valid),
        .drain_op     (drain_op),
        .drain_pos    (drain_pos),
        .drain_addr   (drain_addr),
        .restore_tos  (restore_tos),
        .q_count      (q_count),
        .ord_valid    (ord_valid),
        .ord_push     (ord_push),
        .ord_pos      (ord_pos),
        .ord_addr     (ord_addr)
    );

    ras_backing_stack #(
        .ADDR_W (ADDR_W),
        .DEPTH  (STACK_DEPTH),
        .IDX_W  (IDX_W)
    ) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (drain_valid),
        .wr_push (drain_op == RAS_PUSH),
        .wr_pos  (drain_pos),
        .wr_addr (drain_addr),
        .rd_pos  (spec_tos),
        .rd_addr (backing_addr),
        .cmt_tos (cmt_tos)
    );

    ras_lookup #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .QDEPTH (QUEUE_DEPTH)
    ) u_lookup (
        .ord_valid    (ord_valid),
        .ord_push     (ord_push),
        .ord_pos      (ord_pos),
        .ord_addr     (ord_addr),
        .tos          (spec_tos),
        .backing_addr (backing_addr),
        .pred_addr    (pred_addr)
    );
endmodule

// File: rtl/spec_ras_checker.sv
// Temporal checks on the speculative return address stack, bound to spec_ras.
// It observes the ports plus the queue occupancy and the drain strobe.
module spec_ras_checker #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 4,
    parameter int QDEPTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_push,
    input logic [ADDR_W-1:0] req_addr,
    input logic              flush_valid,
    input logic [IDX_W-1:0]  top_index,
    input logic [ADDR_W-1:0] pred_addr,
    input logic [CNT_W-1:0]  q_count,
    input logic              drain_valid
);
    // R2: an accepted push shows its own address in the next clock
    assert_push_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_push && !flush_valid && q_count < CNT_W'(QDEPTH))
        |=> pred_addr == $past(req_addr));

    // R2: a push moves the top up by one
    assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_push && !flush_valid)
        |=> top_index == IDX_W'($past(top_index) + 1'b1));

    // R3: a pop moves the top down by one
    assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_push && !flush_valid)
        |=> top_index == IDX_W'($past(top_index) - 1'b1));

    // R10: with no request and no flush the top does not move
    assert_idle_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !flush_valid) |=> $stable(top_index));

    // R8: occupancy never exceeds the queue depth
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(QDEPTH));

    // R8: a full queue that neither drains nor flushes stays full
    assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CNT_W'(QDEPTH) && !drain_valid && !flush_valid)
        |=> q_count == CNT_W'(QDEPTH));

    // R7: a drain needs a non-empty queue
    assert_drain_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid |-> q_count != '0);
endmodule

bind spec_ras spec_ras_checker #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W),
    .QDEPTH (QUEUE_DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_push    (req_push),
    .req_addr    (req_addr),
    .flush_valid (flush_valid),
    .top_index   (top_index),
    .pred_addr   (pred_addr),
    .q_count     (q_count),
    .drain_valid (drain_valid)
);

// File: tb/spec_ras_tb.sv
// Directed bench for spec_ras: one task per scenario, each checks its results.
module spec_ras_tb;
    localparam int ADDR_W = 32;
    localparam int TAG_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_push = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              commit_valid = 1'b0;
    logic [TAG_W-1:0]  commit_tag = '0;
    logic              flush_valid = 1'b0;
    logic [TAG_W-1:0]  flush_tag = '0;
    logic [ADDR_W-1:0] pred_addr;
    logic [4:0]        top_index;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    spec_ras u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_push(req_push),
        .req_addr(req_addr), .req_tag(req_tag),
        .commit_valid(commit_valid), .commit_tag(commit_tag),
        .flush_valid(flush_valid), .flush_tag(flush_tag),
        .pred_addr(pred_addr), .top_index(top_index)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp, string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ras_req(logic push, logic [31:0] addr, logic [3:0] tag);
        req_valid = 1'b1; req_push = push; req_addr = addr; req_tag = tag;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ras_commit(logic [3:0] tag);
        commit_valid = 1'b1; commit_tag = tag;
        @(negedge clk);
        commit_valid = 1'b0;
    endtask

    task automatic ras_flush(logic [3:0] tag);
        flush_valid = 1'b1; flush_tag = tag;
        @(negedge clk);
        flush_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", pred_addr, 32'h0, "pred after reset");
        check("R1", 32'(top_index), 32'd0, "top after reset");
    endtask

    task automatic t_push_pop();
        do_reset();
        ras_req(1'b1, 32'hA1, 4'd0);
        check("R2", pred_addr, 32'hA1, "pred after first push");
        ras_req(1'b1, 32'hA2, 4'd0);
        check("R2", pred_addr, 32'hA2, "pred after second push");
        check("R2", 32'(top_index), 32'd2, "top after two pushes");
        ras_req(1'b0, 32'h0, 4'd0);
        check("R3", pred_addr, 32'hA1, "pred after pop");
        check("R3", 32'(top_index), 32'd1, "top after pop");
        ras_req(1'b0, 32'h0, 4'd0);
        check("R3", pred_addr, 32'h0, "pred after popping to empty");
    endtask

    task automatic t_drain();
        do_reset();
        ras_req(1'b1, 32'h11, 4'd0);
        ras_req(1'b1, 32'h22, 4'd1);
        ras_req(1'b0, 32'h0, 4'd1);
        ras_commit(4'd0);
        ras_commit(4'd1);
        idle(5);
        check("R4", pred_addr, 32'h11, "pred served from backing stack");
        check("R4", 32'(top_index), 32'd1, "top after drain");
        // queue is empty, so the flush keeps nothing and restores the committed top
        ras_flush(4'd2);
        check("R7", 32'(top_index), 32'd1, "committed top after drained pop");
        check("R7", pred_addr, 32'h11, "pred after restore to committed top");
    endtask

    task automatic t_overwrite();
        do_reset();
        ras_req(1'b1, 32'hA0, 4'd0);
        ras_req(1'b0, 32'h0, 4'd2);
        check("R3", pred_addr, 32'h0, "pred from backing at position 0");
        ras_req(1'b1, 32'hB0, 4'd2);
        check("R3", pred_addr, 32'hB0, "newest push at position 1 wins");
        ras_flush(4'd1);
        check("R5", 32'(top_index), 32'd1, "top restored from surviving entry");
        check("R5", pred_addr, 32'hA0, "overwritten slot recovered");
        // R10: a push in the flush cycle must not be recorded
        ras_req(1'b1, 32'hC0, 4'd1);
        req_valid = 1'b1; req_push = 1'b1; req_addr = 32'hD0; req_tag = 4'd1;
        ras_flush(4'd0);
        req_valid = 1'b0;
        check("R10", 32'(top_index), 32'd1, "top ignores request in flush cycle");
        check("R10", pred_addr, 32'hA0, "pred ignores request in flush cycle");
    endtask

    task automatic t_empty_restore();
        do_reset();
        ras_req(1'b1, 32'h55, 4'd1);
        ras_flush(4'd0);
        check("R6", 32'(top_index), 32'd0, "top restored to committed top");
        check("R6", pred_addr, 32'h0, "pred after full discard");
    endtask

    task automatic t_full();
        do_reset();
        for (int k = 1; k <= 10; k++) ras_req(1'b1, 32'h100 + 32'(k), 4'd0);
        check("R8", 32'(top_index), 32'd10, "top advances past full queue");
        check("R8", pred_addr, 32'h0, "dropped push is not predicted");
        ras_req(1'b0, 32'h0, 4'd0);
        ras_req(1'b0, 32'h0, 4'd0);
        check("R8", 32'(top_index), 32'd8, "top after pops on full queue");
        check("R8", pred_addr, 32'h108, "last recorded push still predicted");
    endtask

    task automatic t_wrap();
        do_reset();
        for (int k = 1; k <= 33; k++) begin
            ras_req(1'b1, 32'h1000 + 32'(k), 4'((k - 1) % 16));
            ras_commit(4'((k - 1) % 16));
        end
        idle(3);
        check("R9", 32'(top_index), 32'd1, "top wrapped after 33 pushes");
        check("R9", pred_addr, 32'h1021, "wrapped slot holds newest push");
        ras_req(1'b0, 32'h0, 4'd1);
        check("R9", pred_addr, 32'h1020, "position 0 from backing stack");
        ras_req(1'b0, 32'h0, 4'd1);
        check("R9", 32'(top_index), 32'd31, "top wraps below zero");
        check("R9", pred_addr, 32'h101F, "position 31 from backing stack");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_push_pop();
        t_drain();
        t_overwrite();
        t_empty_restore();
        t_full();
        t_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule